// File: doc/BRIEF.md
# Coalescing Serial-Port Interrupt Generator

This block raises interrupt requests for an audio serial port that has a transmit side and a receive side. Each side has a status register of event flags and an enable register. A flag is an active request when it is set and its enable bit is set. Hardware sets flags through per-side event inputs. Software reads the registers and clears flags by writing ones to a status register.

Each side keeps at most one outstanding request. The first active request on an idle side produces a one-cycle pulse on that side's interrupt output. Any request that becomes active afterwards is folded into the outstanding one. Once software writes the side's status register, the side is idle again, and it pulses again at once if any flag is still both set and enabled. The coalescing covers interrupts only. Any DMA request path is separate and is not affected.

Top module: `sp_irq_coalescer`

## Requirements
- R1: A flag produces an interrupt only while it is set and its matching enable bit is 1. A set flag whose enable bit is 0 leaves the output low.
- R2: A request pulse on `tx_irq` or `rx_irq` lasts exactly one clock cycle. It appears in the cycle after the register update that made a request active.
- R3: Several requests that become active in the same cycle on one side produce one single pulse.
- R4: While a side has an outstanding request, new events or enable changes on that side produce no pulse.
- R5: The two sides are independent. A pulse can occur on one side while the other is outstanding, and both sides may pulse in the same cycle.
- R6: Any write to a side's status register ends that side's outstanding request. If any flag is still set and enabled after the write, a new pulse follows in the next cycle. Otherwise no pulse follows.
- R7: Register map at `addr`: 0 is the transmit status register, 1 is the transmit enable register, 2 is the receive status register, and 3 is the receive enable register. A status write clears the bits written as 1. An enable write replaces the whole register. `rdata` shows the addressed register combinationally.
- R8: When an event sets a flag in the same cycle that software writes a 1 to clear it, the flag stays set.
- R9: On an idle side, writing the enable register so that a set flag becomes enabled produces a pulse.
- R10: Reset clears all flags, enables and outstanding state. Both interrupt outputs are low during reset and after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_evt | input | NFLAGS | Transmit flag set strobes |
| rx_evt | input | NFLAGS | Receive flag set strobes |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | NFLAGS | Write data |
| rdata | output | NFLAGS | Read data of the addressed register |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench builds the block with NFLAGS = 4. That width is small enough to drive every flag on purpose, and it still includes a top flag, bit 3. The bench enables only the low bits at first, so disabled flags can be shown to stay silent, and then enables all of them. It also writes a clear in the same cycle as an event, services one side while the other is outstanding, and fires both sides together.

// File: rtl/sp_irq_coalescer.sv
module sp_irq_coalescer #(
  parameter int NFLAGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] tx_evt,
  input  logic [NFLAGS-1:0] rx_evt,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [NFLAGS-1:0] wdata,
  output logic [NFLAGS-1:0] rdata,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam logic [1:0] A_TXS = 2'd0, A_TXE = 2'd1, A_RXS = 2'd2, A_RXE = 2'd3;

  logic [NFLAGS-1:0] tx_stat, tx_en, rx_stat, rx_en;
  logic              tx_pend, rx_pend;

  wire wr_txs = wr_en && addr == A_TXS;
  wire wr_txe = wr_en && addr == A_TXE;
  wire wr_rxs = wr_en && addr == A_RXS;
  wire wr_rxe = wr_en && addr == A_RXE;

  wire tx_act = |(tx_stat & tx_en);
  wire rx_act = |(rx_stat & rx_en);

  assign tx_irq = tx_act && !tx_pend;
  assign rx_irq = rx_act && !rx_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_stat <= '0;
      tx_en   <= '0;
      rx_stat <= '0;
      rx_en   <= '0;
      tx_pend <= 1'b0;
      rx_pend <= 1'b0;
    end else begin
      tx_stat <= (tx_stat & ~(wr_txs ? wdata : '0)) | tx_evt;
      rx_stat <= (rx_stat & ~(wr_rxs ? wdata : '0)) | rx_evt;
      if (wr_txe) tx_en <= wdata;
      if (wr_rxe) rx_en <= wdata;
      tx_pend <= wr_txs ? 1'b0 : (tx_pend | tx_irq);
      rx_pend <= wr_rxs ? 1'b0 : (rx_pend | rx_irq);
    end
  end

  always_comb begin
    unique case (addr)
      A_TXS:   rdata = tx_stat;
      A_TXE:   rdata = tx_en;
      A_RXS:   rdata = rx_stat;
      default: rdata = rx_en;
    endcase
  end
endmodule

module sp_irq_coalescer_chk #(
  parameter int NFLAGS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NFLAGS-1:0] tx_evt,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic [NFLAGS-1:0] tx_stat,
  input logic [NFLAGS-1:0] tx_en,
  input logic [NFLAGS-1:0] rx_stat,
  input logic [NFLAGS-1:0] rx_en
);
  logic tx_seen, rx_seen;
  wire  wtx = wr_en && addr == 2'd0;
  wire  wrx = wr_en && addr == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_seen <= 1'b0;
      rx_seen <= 1'b0;
    end else begin
      tx_seen <= wtx ? 1'b0 : (tx_seen | tx_irq);
      rx_seen <= wrx ? 1'b0 : (rx_seen | rx_irq);
    end
  end

  p_tx_needs_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tx_stat & tx_en) != '0);
  p_rx_needs_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_stat & rx_en) != '0);
  p_tx_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !wtx) |=> !tx_irq);
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_seen |-> !tx_irq);
  p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_seen |-> !rx_irq);
  p_tx_repulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wtx |=> (tx_irq == ((tx_stat & tx_en) != '0)));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt != '0) |=> ((tx_stat & $past(tx_evt)) == $past(tx_evt)));
endmodule

bind sp_irq_coalescer sp_irq_coalescer_chk #(.NFLAGS(NFLAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .wr_en(wr_en), .addr(addr),
  .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_stat(tx_stat), .tx_en(tx_en),
  .rx_stat(rx_stat), .rx_en(rx_en)
);

// File: tb/sp_irq_coalescer_test.sv
module sp_irq_coalescer_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] tx_evt = '0, rx_evt = '0, wdata = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [N-1:0] rdata;
  logic         tx_irq, rx_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic         etx, erx, rchk;
    logic [N-1:0] erd;
    string        tag;
  } exp_t;
  exp_t q[$];

  sp_irq_coalescer #(.NFLAGS(N)) uut (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (tx_irq !== e.etx || rx_irq !== e.erx ||
          (e.rchk && rdata !== e.erd)) begin
        errors++;
        $display("FAIL %s: tx=%0b rx=%0b rd=%b expected tx=%0b rx=%0b rd=%b",
                 e.tag, tx_irq, rx_irq, rdata, e.etx, e.erx, e.erd);
      end
    end
  end

  task automatic step(input logic [N-1:0] te, re, input logic w,
                      input logic [1:0] a, input logic [N-1:0] d,
                      input logic xt, xr, rc, input logic [N-1:0] xd,
                      input string tag);
    exp_t e;
    @(negedge clk);
    tx_evt = te; rx_evt = re; wr_en = w; addr = a; wdata = d;
    e.etx = xt; e.erx = xr; e.rchk = rc; e.erd = xd; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (tx_irq !== 1'b0 || rx_irq !== 1'b0 || rdata !== '0) begin
      errors++;
      $display("FAIL R10: tx=%0b rx=%0b rd=%b expected 0 0 0000", tx_irq, rx_irq, rdata);
    end
    rst_n = 1'b1;
    step('0, '0, 1, 2'd1, 4'b0011, 0, 0, 1, 4'b0011, "R7 tx enable write");
    step(4'b0100, '0, 0, 2'd0, '0, 0, 0, 1, 4'b0100, "R1 disabled flag silent");
    step(4'b0011, '0, 0, 2'd0, '0, 1, 0, 0, '0, "R3 two flags one pulse");
    step('0, '0, 0, 2'd0, '0, 0, 0, 0, '0, "R2 pulse one cycle");
    step(4'b1000, '0, 0, 2'd0, '0, 0, 0, 1, 4'b1111, "R4 event while outstanding");
    step('0, '0, 1, 2'd1, 4'b1111, 0, 0, 0, '0, "R4 enable while outstanding");
    step('0, 4'b0001, 0, 2'd2, '0, 0, 0, 1, 4'b0001, "R1 rx disabled");
    step('0, '0, 1, 2'd3, 4'b0001, 0, 1, 0, '0, "R9 R5 rx enable pulses");
    step('0, '0, 0, 2'd0, '0, 0, 0, 0, '0, "R2 rx one cycle");
    step('0, '0, 1, 2'd0, 4'b0001, 1, 0, 1, 4'b1110, "R6 repulse after partial clear");
    step('0, '0, 0, 2'd0, '0, 0, 0, 0, '0, "R2 after repulse");
    step('0, 4'b0001, 1, 2'd0, 4'b1110, 0, 0, 1, 4'b0000, "R6 full clear no pulse");
    step(4'b0010, '0, 1, 2'd0, 4'b0010, 1, 0, 1, 4'b0010, "R8 set wins over clear");
    step('0, '0, 0, 2'd0, '0, 0, 0, 1, 4'b0010, "R8 flag kept");
    step('0, '0, 1, 2'd2, 4'b0001, 0, 0, 1, 4'b0000, "R6 rx cleared");
    step('0, '0, 1, 2'd0, 4'b0010, 0, 0, 0, '0, "R6 tx cleared");
    step(4'b1000, 4'b0001, 0, 2'd3, '0, 1, 1, 1, 4'b0001, "R5 both sides pulse");
    step('0, '0, 0, 2'd1, '0, 0, 0, 1, 4'b1111, "R7 enable readback");
    @(negedge clk);
    tx_evt = '0; rx_evt = '0; wr_en = 0;
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule